// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block decides when a small processor core may drop into a low-power state and how it comes back. The core raises a one-cycle sleep request when it executes its sleep instruction. The request only has effect while a sleep-enable bit is set. A two-bit mode code chooses how deep the sleep is: light (Idle), converter-quiet (Noise Reduction) or deepest (Power-down). The code 11 is reserved and behaves as Idle. The mode is latched when sleep begins.

While asleep, the block drives four clock-gating enables: the core clock, the general peripheral clock, the converter clock and the main oscillator. Only the wake sources that the latched mode allows can end the sleep. Power-down is the special case. Its level-type wake inputs are filtered by a slow sampling strobe. After a wake, the oscillator gets a selectable settle period of 16, 256, 1024 or 4096 cycles. Every interrupt wake then holds the core for a fixed four cycles. A one-cycle release pulse follows, and the core resumes into interrupt service. A reset request during sleep skips all of this. It returns the core to running at once and flags a restart from the reset vector.

Top module: `sleepWakeCtrl`

## Requirements
- R1: Out of reset all four clock enables are 1 and `irqGo`, `resetGo`, `adcStart` are 0. Sleep begins on the edge where `sleepReq` and `sleepEn` are both 1. A request with `sleepEn` at 0 leaves `cpuClkEn` at 1.
- R2: While asleep, the enables {cpu, io, adc, osc} are as follows. Mode 00 (Idle) gives 0,1,1,1. Mode 01 (Noise Reduction) gives 0,0,1,1. Mode 10 (Power-down) gives 0,0,0,0. `oscEn` at 0 always implies the other three are 0.
- R3: Mode code 11 behaves exactly like Idle, both for clock enables and for wake sources.
- R4: In Idle, any of `wakeOther`, `wakeExtLevel`, `wakePinChg`, `wakeAdcDone` or `wakeWdt` ends sleep on the next edge and enters the hold phase.
- R5: In Noise Reduction, `wakeExtLevel`, `wakePinChg`, `wakeAdcDone` and `wakeWdt` end sleep. `wakeOther` is ignored.
- R6: In Power-down, `wakeOther`, `wakeAdcDone` and `wakeWdt` are ignored. `wakeExtLevel` or `wakePinChg` counts only when seen high on two successive `slowTick` samples. A single high sample, or a high sample after a low one, does not wake.
- R7: A Power-down wake raises `oscEn` with `cpuClkEn` still 0. It then waits a settle period chosen by `startSel`: 00=16, 01=256, 10=1024, 11=4096 cycles.
- R8: After an interrupt wake, `cpuClkEn` stays 0 for exactly four hold cycles. Then `irqGo` and `cpuClkEn` are 1 for one cycle, followed by normal running with `irqGo` 0.
- R9: `wakeReset` high during sleep, settle or hold returns the core to running on the next edge. `resetGo` is 1 for that one cycle, and `irqGo` is not raised.
- R10: Entering Idle or Noise Reduction with `adcEnabled` at 1 gives a one-cycle `adcStart` pulse in the first sleep cycle. Entering Power-down never pulses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle strobe marking a slow-clock sample point |
| sleepReq | input | 1 | Sleep instruction executed (one-cycle pulse) |
| sleepEn | input | 1 | Sleep permitted |
| modeSel | input | 2 | Sleep depth code |
| startSel | input | 2 | Oscillator settle length selector |
| adcEnabled | input | 1 | Converter is switched on |
| wakeOther | input | 1 | Any other enabled interrupt (timers, comparator) |
| wakeExtLevel | input | 1 | Level-type external interrupt request |
| wakePinChg | input | 1 | Pin-change interrupt request |
| wakeAdcDone | input | 1 | Conversion-complete interrupt request |
| wakeWdt | input | 1 | Watchdog time-out interrupt request |
| wakeReset | input | 1 | External or watchdog reset request |
| cpuClkEn | output | 1 | Core clock enable |
| ioClkEn | output | 1 | Timer and general peripheral clock enable |
| adcClkEn | output | 1 | Converter clock enable |
| oscEn | output | 1 | Main oscillator enable |
| adcStart | output | 1 | Start a conversion (one-cycle pulse) |
| irqGo | output | 1 | Hold finished; begin interrupt service (pulse) |
| resetGo | output | 1 | Reset wake; restart from reset vector (pulse) |

## Verification
The bench checks every mode against sources it must honour and sources it must ignore. A design that leaked the wrong source would wake from Noise Reduction on a timer interrupt, or from Power-down on a watchdog interrupt, and the core clock would come back early.

The Power-down filter is probed with a single high sample and with a high-low-high pattern. A filter that kept no history, or that counted non-adjacent samples, would raise the oscillator too soon.

Settle and hold lengths are counted edge by edge for several selector codes, so an off-by-one in the shared counter shows up as a wrong release cycle. A reset during settle must bring the core back with no interrupt release.

// File: rtl/sleepWakePkg.sv
package sleepWakePkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RESUME = 3'd4
  } sleepState_e;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_NOISE = 2'd1,
    MD_PDOWN = 2'd2
  } effMode_e;

  // control -> datapath
  typedef struct packed {
    logic loadSettle;
    logic loadHold;
    logic countDown;
    logic clrFilter;
    logic filtRun;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic cntZero;
    logic filtWake;
  } dpStatus_t;

  // reserved code 11 folds onto Idle
  function automatic effMode_e decodeMode(input logic [1:0] code);
    case (code)
      2'b01:   return MD_NOISE;
      2'b10:   return MD_PDOWN;
      default: return MD_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sleepWakeDp.sv
module sleepWakeDp
  import sleepWakePkg::*;
#(
  parameter int DLY0         = 16,
  parameter int DLY1         = 256,
  parameter int DLY2         = 1024,
  parameter int DLY3         = 4096,
  parameter int HOLD_CYCLES  = 4,
  parameter int FILT_SAMPLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [1:0]   startSel,
  input  logic         slowTick,
  input  logic         levelWake,
  output dpStatus_t    status
);

  localparam int MAX01 = (DLY0 > DLY1) ? DLY0 : DLY1;
  localparam int MAX23 = (DLY2 > DLY3) ? DLY2 : DLY3;
  localparam int MAXD  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int MAXC  = (MAXD > HOLD_CYCLES) ? MAXD : HOLD_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] settleLoad;

  always_comb begin
    case (startSel)
      2'd0:    settleLoad = CNT_W'(DLY0 - 1);
      2'd1:    settleLoad = CNT_W'(DLY1 - 1);
      2'd2:    settleLoad = CNT_W'(DLY2 - 1);
      default: settleLoad = CNT_W'(DLY3 - 1);
    endcase
  end

  // one down-counter shared by the settle and hold phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cnt <= '0;
    else if (strobes.loadSettle)              cnt <= settleLoad;
    else if (strobes.loadHold)                cnt <= CNT_W'(HOLD_CYCLES - 1);
    else if (strobes.countDown && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign status.cntZero = (cnt == '0);

  // level wake filter: successive slow-clock samples must all be high
  logic [FILT_SAMPLES-1:0] samp;

  generate
    if (FILT_SAMPLES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                            samp <= '0;
        else if (strobes.clrFilter)           samp <= '0;
        else if (strobes.filtRun && slowTick) samp <= levelWake;
      end
    end else begin : gShift
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                            samp <= '0;
        else if (strobes.clrFilter)           samp <= '0;
        else if (strobes.filtRun && slowTick) samp <= {samp[FILT_SAMPLES-2:0], levelWake};
      end
    end
  endgenerate

  assign status.filtWake = &samp;

endmodule

// File: rtl/sleepWakeFsm.sv
module sleepWakeFsm
  import sleepWakePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepReq,
  input  logic         sleepEn,
  input  logic [1:0]   modeSel,
  input  logic         adcEnabled,
  input  logic         wakeOther,
  input  logic         wakeExtLevel,
  input  logic         wakePinChg,
  input  logic         wakeAdcDone,
  input  logic         wakeWdt,
  input  logic         wakeReset,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         cpuClkEn,
  output logic         ioClkEn,
  output logic         adcClkEn,
  output logic         oscEn,
  output logic         adcStart,
  output logic         irqGo,
  output logic         resetGo
);

  sleepState_e state, nxt;
  effMode_e    mode;
  effMode_e    reqMode;
  logic        enter;
  logic        wakeNow;
  logic        inSleep;
  logic        adcStartQ;
  logic        resetGoQ;

  assign reqMode = decodeMode(modeSel);
  assign enter   = (state == ST_RUN) && sleepReq && sleepEn;
  assign inSleep = (state == ST_SLEEP) || (state == ST_SETTLE) || (state == ST_HOLD);

  // wake qualification by latched mode
  always_comb begin
    case (mode)
      MD_NOISE: wakeNow = wakeExtLevel | wakePinChg | wakeAdcDone | wakeWdt;
      MD_PDOWN: wakeNow = status.filtWake;
      default:  wakeNow = wakeOther | wakeExtLevel | wakePinChg | wakeAdcDone | wakeWdt;
    endcase
  end

  always_comb begin
    nxt     = state;
    strobes = '0;
    case (state)
      ST_RUN: begin
        if (enter) begin
          nxt               = ST_SLEEP;
          strobes.clrFilter = 1'b1;
        end
      end
      ST_SLEEP: begin
        strobes.filtRun = (mode == MD_PDOWN);
        if (wakeReset) begin
          nxt = ST_RUN;
        end else if (wakeNow) begin
          if (mode == MD_PDOWN) begin
            nxt                = ST_SETTLE;
            strobes.loadSettle = 1'b1;
          end else begin
            nxt              = ST_HOLD;
            strobes.loadHold = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        strobes.countDown = 1'b1;
        if (wakeReset) begin
          nxt = ST_RUN;
        end else if (status.cntZero) begin
          nxt              = ST_HOLD;
          strobes.loadHold = 1'b1;
        end
      end
      ST_HOLD: begin
        strobes.countDown = 1'b1;
        if (wakeReset)            nxt = ST_RUN;
        else if (status.cntZero)  nxt = ST_RESUME;
      end
      ST_RESUME: nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      mode      <= MD_IDLE;
      adcStartQ <= 1'b0;
      resetGoQ  <= 1'b0;
    end else begin
      state     <= nxt;
      if (enter) mode <= reqMode;
      adcStartQ <= enter && adcEnabled && (reqMode != MD_PDOWN);
      resetGoQ  <= inSleep && wakeReset;
    end
  end

  // clock gating per state and latched mode
  always_comb begin
    cpuClkEn = 1'b1;
    ioClkEn  = 1'b1;
    adcClkEn = 1'b1;
    oscEn    = 1'b1;
    case (state)
      ST_SLEEP: begin
        cpuClkEn = 1'b0;
        ioClkEn  = (mode == MD_IDLE);
        adcClkEn = (mode != MD_PDOWN);
        oscEn    = (mode != MD_PDOWN);
      end
      ST_SETTLE: begin
        cpuClkEn = 1'b0;
        ioClkEn  = 1'b0;
        adcClkEn = 1'b0;
      end
      ST_HOLD: cpuClkEn = 1'b0;
      default: ;
    endcase
  end

  assign adcStart = adcStartQ;
  assign irqGo    = (state == ST_RESUME);
  assign resetGo  = resetGoQ;

endmodule

// File: rtl/sleepWakeCtrl.sv
module sleepWakeCtrl
  import sleepWakePkg::*;
#(
  parameter int DLY0         = 16,
  parameter int DLY1         = 256,
  parameter int DLY2         = 1024,
  parameter int DLY3         = 4096,
  parameter int HOLD_CYCLES  = 4,
  parameter int FILT_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic       sleepReq,
  input  logic       sleepEn,
  input  logic [1:0] modeSel,
  input  logic [1:0] startSel,
  input  logic       adcEnabled,
  input  logic       wakeOther,
  input  logic       wakeExtLevel,
  input  logic       wakePinChg,
  input  logic       wakeAdcDone,
  input  logic       wakeWdt,
  input  logic       wakeReset,
  output logic       cpuClkEn,
  output logic       ioClkEn,
  output logic       adcClkEn,
  output logic       oscEn,
  output logic       adcStart,
  output logic       irqGo,
  output logic       resetGo
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  sleepWakeFsm fsm_i (
    .clk(clk), .rstN(rstN),
    .sleepReq(sleepReq), .sleepEn(sleepEn), .modeSel(modeSel), .adcEnabled(adcEnabled),
    .wakeOther(wakeOther), .wakeExtLevel(wakeExtLevel), .wakePinChg(wakePinChg),
    .wakeAdcDone(wakeAdcDone), .wakeWdt(wakeWdt), .wakeReset(wakeReset),
    .status(status), .strobes(strobes),
    .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn), .oscEn(oscEn),
    .adcStart(adcStart), .irqGo(irqGo), .resetGo(resetGo)
  );

  sleepWakeDp #(
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3),
    .HOLD_CYCLES(HOLD_CYCLES), .FILT_SAMPLES(FILT_SAMPLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startSel(startSel),
    .slowTick(slowTick), .levelWake(wakeExtLevel | wakePinChg), .status(status)
  );

endmodule

// File: rtl/sleepWakeChk.sv
module sleepWakeChk (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic sleepEn,
  input logic cpuClkEn,
  input logic ioClkEn,
  input logic adcClkEn,
  input logic oscEn,
  input logic adcStart,
  input logic irqGo,
  input logic resetGo
);

  AST_ENTRY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuClkEn) |-> $past(sleepReq && sleepEn)); // R1

  AST_OSC_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && !ioClkEn && !adcClkEn)); // R2

  AST_OSC_RESTART_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(oscEn) && !resetGo) |-> !cpuClkEn); // R7

  AST_CPU_BACK_VIA_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuClkEn) && !resetGo) |-> irqGo); // R8

  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqGo |=> !irqGo); // R8

  AST_RELEASE_NOT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    irqGo |-> !resetGo); // R9

  AST_RESET_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    resetGo |-> (cpuClkEn && oscEn)); // R9

  AST_ADC_START_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> (!cpuClkEn && oscEn && adcClkEn)); // R10

endmodule

bind sleepWakeCtrl sleepWakeChk chk_i (
  .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepEn(sleepEn),
  .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn), .oscEn(oscEn),
  .adcStart(adcStart), .irqGo(irqGo), .resetGo(resetGo)
);

// File: tb/sleepWakeCtrl_tb_top.sv
module sleepWakeCtrl_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 0, sleepReq = 0, sleepEn = 0, adcEnabled = 0;
  logic [1:0] modeSel = 0, startSel = 0;
  logic wakeOther = 0, wakeExtLevel = 0, wakePinChg = 0, wakeAdcDone = 0, wakeWdt = 0, wakeReset = 0;
  logic cpuClkEn, ioClkEn, adcClkEn, oscEn, adcStart, irqGo, resetGo;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sleepWakeCtrl dut_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .sleepReq(sleepReq), .sleepEn(sleepEn),
    .modeSel(modeSel), .startSel(startSel), .adcEnabled(adcEnabled),
    .wakeOther(wakeOther), .wakeExtLevel(wakeExtLevel), .wakePinChg(wakePinChg),
    .wakeAdcDone(wakeAdcDone), .wakeWdt(wakeWdt), .wakeReset(wakeReset),
    .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn), .oscEn(oscEn),
    .adcStart(adcStart), .irqGo(irqGo), .resetGo(resetGo)
  );

  // {mode[1:0], other, ext, pin, adc, wdt, expectWake}
  localparam logic [7:0] VEC [11] = '{
    8'b00_10000_1,  // Idle, timer-type irq
    8'b00_00001_1,  // Idle, watchdog irq
    8'b00_00100_1,  // Idle, pin change
    8'b01_10000_0,  // Noise, timer-type irq ignored
    8'b01_00010_1,  // Noise, conversion done
    8'b01_01000_1,  // Noise, external level
    8'b11_10000_1,  // reserved -> Idle
    8'b10_00001_0,  // Power-down, watchdog irq ignored
    8'b10_00010_0,  // Power-down, conversion done ignored
    8'b10_10000_0,  // Power-down, timer-type irq ignored
    8'b10_01000_0   // Power-down, level without slow samples
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expEn(input logic [1:0] m);
    case (m)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic string wakeReq(input logic [1:0] m);
    case (m)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic enterSleep(input logic [1:0] m, input logic adcOn);
    modeSel    = m;
    sleepEn    = 1'b1;
    adcEnabled = adcOn;
    sleepReq   = 1'b1;
    tick();
    sleepReq   = 1'b0;
  endtask

  task automatic slowSample(input logic lvl);
    wakeExtLevel = lvl;
    slowTick     = 1'b1;
    tick();
    slowTick     = 1'b0;
  endtask

  task automatic holdAndRelease();
    for (int h = 0; h < 4; h++) begin
      chk("R8 hold cpu off", {31'd0, cpuClkEn | irqGo}, 32'd0);
      tick();
    end
    chk("R8 release", {30'd0, irqGo, cpuClkEn}, 32'd3);
    tick();
    chk("R8 after release", {30'd0, irqGo, cpuClkEn}, 32'd1);
  endtask

  task automatic settleLen(input logic [1:0] sel, input int expCycles);
    int k;
    startSel = sel;
    enterSleep(2'b10, 1'b0);
    slowSample(1'b1);
    slowSample(1'b1);
    tick();
    chk("R7 osc restarts, cpu off", {30'd0, oscEn, cpuClkEn}, 32'd2);
    k = 0;
    while (!irqGo && k < 5000) begin
      tick();
      k++;
    end
    chk("R7 R8 settle plus hold length", k, expCycles);
    wakeExtLevel = 1'b0;
    tick();
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 reset enables", {28'd0, cpuClkEn, ioClkEn, adcClkEn, oscEn}, 32'hF);
    chk("R1 reset pulses", {29'd0, adcStart, irqGo, resetGo}, 32'd0);

    // R1 request without enable
    sleepEn  = 1'b0;
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    chk("R1 no sleep without enable", {31'd0, cpuClkEn}, 32'd1);
    tick();

    // mode / source table
    for (int i = 0; i < 11; i++) begin
      logic [1:0] m;
      m = VEC[i][7:6];
      enterSleep(m, 1'b0);
      chk((m == 2'b11) ? "R3 sleep clocks" : "R2 sleep clocks",
          {28'd0, cpuClkEn, ioClkEn, adcClkEn, oscEn}, {28'd0, expEn(m)});
      {wakeOther, wakeExtLevel, wakePinChg, wakeAdcDone, wakeWdt} = VEC[i][5:1];
      tick();
      if (VEC[i][0]) begin
        {wakeOther, wakeExtLevel, wakePinChg, wakeAdcDone, wakeWdt} = 5'd0;
        chk(wakeReq(m), {31'd0, ioClkEn & ~cpuClkEn}, 32'd1);
        holdAndRelease();
      end else begin
        tick();
        tick();
        {wakeOther, wakeExtLevel, wakePinChg, wakeAdcDone, wakeWdt} = 5'd0;
        chk(wakeReq(m), {28'd0, cpuClkEn, ioClkEn, adcClkEn, oscEn}, {28'd0, expEn(m)});
        wakeReset = 1'b1;
        tick();
        wakeReset = 1'b0;
        chk("R9 reset wake", {29'd0, resetGo, cpuClkEn, irqGo}, 32'd6);
        tick();
        chk("R9 reset pulse ends", {31'd0, resetGo}, 32'd0);
      end
    end

    // R10 conversion start on entry
    enterSleep(2'b00, 1'b1);
    chk("R10 start pulse in Idle", {31'd0, adcStart}, 32'd1);
    tick();
    chk("R10 start pulse one cycle", {31'd0, adcStart}, 32'd0);
    wakeOther = 1'b1;
    tick();
    wakeOther = 1'b0;
    holdAndRelease();
    enterSleep(2'b10, 1'b1);
    chk("R10 no start in Power-down", {31'd0, adcStart}, 32'd0);

    // R6 filter patterns
    startSel = 2'd0;
    slowSample(1'b1);
    tick();
    tick();
    chk("R6 one sample not enough", {31'd0, oscEn}, 32'd0);
    slowSample(1'b0);
    slowSample(1'b1);
    tick();
    tick();
    chk("R6 high-low-high no wake", {31'd0, oscEn}, 32'd0);
    slowSample(1'b1);
    tick();
    chk("R6 two successive highs wake", {30'd0, oscEn, cpuClkEn}, 32'd2);
    k_wait_release();
    wakeExtLevel = 1'b0;
    tick();

    // R7 settle lengths: settle + 4 hold
    settleLen(2'd1, 260);
    settleLen(2'd3, 4100);

    // R9 reset during settle
    startSel = 2'd2;
    enterSleep(2'b10, 1'b0);
    slowSample(1'b1);
    slowSample(1'b1);
    tick();
    wakeExtLevel = 1'b0;
    tick();
    chk("R9 in settle", {30'd0, oscEn, cpuClkEn}, 32'd2);
    wakeReset = 1'b1;
    tick();
    wakeReset = 1'b0;
    chk("R9 reset from settle", {29'd0, resetGo, cpuClkEn, irqGo}, 32'd6);
    for (int j = 0; j < 8; j++) begin
      if (irqGo) chk("R9 no release after reset", 32'd1, 32'd0);
      tick();
    end
    chk("R9 running after reset", {31'd0, cpuClkEn}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic k_wait_release();
    int k;
    k = 0;
    while (!irqGo && k < 100) begin
      tick();
      k++;
    end
    chk("R7 R8 shortest settle plus hold", k, 20);
  endtask

endmodule